// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a small 32-bit load/store processor and picks the address of the next instruction to fetch. On each enabled clock it reads the instruction word that is being fetched and decodes its 6-bit opcode. It also reads a one-bit "branch condition holds" flag from a comparator outside the block. From these it chooses one of three successors: the next sequential word, a PC-relative conditional branch target, or a jump target. For a jump, the word address carried in the instruction replaces the lower bits of the PC.

The fetch stage drives the instruction word and the comparator result, and takes the registered `pc` as the fetch address. A low `en` freezes the counter during a stall. A synchronous, active-low reset returns the counter to address zero. There are no delay slots: a branch or jump takes effect on the very next fetch.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes 0x00000000 after that edge. This holds whatever the value of `en`.
- R2: While `rst_n` is high and `en` is low, `pc` keeps its value across the edge, whatever the instruction and the condition flag are.
- R3: When enabled, any opcode (bits 31:26) other than 2 and 5 advances `pc` by 4. The addition wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R4: When enabled, opcode 5 with `cond_true` high loads `pc + (offset << 2)`. The offset is instr[15:0], a signed word count, and the addition is modulo 2^32.
- R5: The branch offset is sign-extended from bit 15. The most negative offset 0x8000 moves `pc` back by 131072 bytes, and offset 0xFFF7 moves it back by 36 bytes.
- R6: When enabled, opcode 5 with `cond_true` low advances `pc` by 4.
- R7: When enabled, opcode 2 loads {pc[31:28], instr[25:0], 2'b00}. This does not depend on `cond_true`.
- R8: `cond_true` has no effect for any opcode other than 5. For example, opcode 4 with `cond_true` high advances `pc` by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction word being fetched at `pc` |
| cond_true | input | 1 | Branch comparison result from outside the block |
| pc | output | 32 | Registered program counter |

## Verification
The only state is the PC register. A wrong successor choice or a bad target calculation therefore shows up on `pc` one clock after the instruction that caused it, and it stays visible until the next reset. Each directed step compares `pc` right after the edge, so an error is caught in the cycle where it happens. Because the upper PC bits carry into jump targets, a corrupted upper nibble also reappears at the next jump.

// File: rtl/nextpc_pkg.sv
// Package: nextpc_pkg
// Purpose: shared types and default encodings for the next-PC unit.
// Assumes: opcodes are 6-bit unsigned values taken from the top of the word.
package nextpc_pkg;

    // Which successor address the unit loads on an enabled edge
    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2
    } next_sel_t;

    localparam int unsigned DEF_OPC_W      = 6;
    localparam int unsigned DEF_OPC_BRANCH = 5;
    localparam int unsigned DEF_OPC_JUMP   = 2;

endpackage

// File: rtl/nextpc_decode.sv
// Module: nextpc_decode
// Purpose: classify the fetched opcode into a successor selection.
// Assumes: only the branch opcode looks at the condition flag; the jump
//          opcode is unconditional; every other opcode is sequential.
module nextpc_decode
    import nextpc_pkg::*;
#(
    parameter int unsigned OPC_W      = DEF_OPC_W,
    parameter int unsigned OPC_BRANCH = DEF_OPC_BRANCH,
    parameter int unsigned OPC_JUMP   = DEF_OPC_JUMP
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             cond_true,
    output next_sel_t        sel
);

    localparam logic [OPC_W-1:0] BR_CODE = OPC_W'(OPC_BRANCH);
    localparam logic [OPC_W-1:0] JP_CODE = OPC_W'(OPC_JUMP);

    // Pick the successor class from the opcode and the condition flag
    always_comb begin
        if (opcode == JP_CODE) begin
            sel = SEL_JUMP;
        end else if ((opcode == BR_CODE) && cond_true) begin
            sel = SEL_BRANCH;
        end else begin
            sel = SEL_SEQ;
        end
    end

endmodule

// File: rtl/nextpc_target.sv
// Module: nextpc_target
// Purpose: form the three candidate addresses and select one of them.
// Assumes: instructions are word aligned (ALIGN low bits are zero); the
//          branch offset and the jump field are word counts; all sums wrap.
module nextpc_target
    import nextpc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned TGT_W   = 26,
    parameter int unsigned ALIGN   = 2
) (
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [INSTR_W-1:0] instr,
    input  next_sel_t          sel,
    output logic [ADDR_W-1:0]  pc_next
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W - ALIGN;
    localparam int unsigned UP_W  = ADDR_W - TGT_W - ALIGN;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    logic [OFF_W-1:0]  off_field;
    logic [TGT_W-1:0]  tgt_field;
    logic [ADDR_W-1:0] off_bytes;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jp_addr;

    assign off_field = instr[OFF_W-1:0];
    assign tgt_field = instr[TGT_W-1:0];

    // Sign-extend the offset and scale it to bytes; the layout depends on ALIGN
    generate
        if (ALIGN == 0) begin : g_noscale
            assign off_bytes = {{EXT_W{off_field[OFF_W-1]}}, off_field};
            assign jp_addr   = {pc_cur[ADDR_W-1 -: UP_W], tgt_field};
        end else begin : g_scale
            assign off_bytes = {{EXT_W{off_field[OFF_W-1]}}, off_field, {ALIGN{1'b0}}};
            assign jp_addr   = {pc_cur[ADDR_W-1 -: UP_W], tgt_field, {ALIGN{1'b0}}};
        end
    endgenerate

    // Sequential and PC-relative candidates, both modulo 2^ADDR_W
    always_comb begin
        seq_addr = pc_cur + STEP;
        br_addr  = pc_cur + off_bytes;
    end

    // Choose the successor named by the decoder
    always_comb begin
        unique case (sel)
            SEL_BRANCH: pc_next = br_addr;
            SEL_JUMP:   pc_next = jp_addr;
            default:    pc_next = seq_addr;
        endcase
    end

endmodule

// File: rtl/nextpc_reg.sv
// Module: nextpc_reg
// Purpose: the program counter register with synchronous reset and hold.
// Assumes: reset wins over enable; RESET_PC is word aligned.
module nextpc_reg #(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Load the reset address, the new address, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_PC;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/nextpc_unit.sv
// Module: nextpc_unit
// Purpose: top of the next-PC unit; decode, target formation and PC register.
// Assumes: instr is the word fetched at the current pc, and cond_true belongs
//          to that same word; there are no delay slots.
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned INSTR_W    = 32,
    parameter int unsigned OPC_W      = DEF_OPC_W,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned TGT_W      = 26,
    parameter int unsigned ALIGN      = 2,
    parameter int unsigned OPC_BRANCH = DEF_OPC_BRANCH,
    parameter int unsigned OPC_JUMP   = DEF_OPC_JUMP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [INSTR_W-1:0] instr,
    input  logic               cond_true,
    output logic [ADDR_W-1:0]  pc
);

    next_sel_t         sel;
    logic [ADDR_W-1:0] pc_next;

    nextpc_decode #(
        .OPC_W      (OPC_W),
        .OPC_BRANCH (OPC_BRANCH),
        .OPC_JUMP   (OPC_JUMP)
    ) u_decode (
        .opcode    (instr[INSTR_W-1 -: OPC_W]),
        .cond_true (cond_true),
        .sel       (sel)
    );

    nextpc_target #(
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W),
        .OFF_W   (OFF_W),
        .TGT_W   (TGT_W),
        .ALIGN   (ALIGN)
    ) u_target (
        .pc_cur  (pc),
        .instr   (instr),
        .sel     (sel),
        .pc_next (pc_next)
    );

    nextpc_reg #(
        .ADDR_W   (ADDR_W),
        .RESET_PC ('0)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (pc_next),
        .q     (pc)
    );

endmodule

// File: rtl/nextpc_unit_chk.sv
// Module: nextpc_unit_chk
// Purpose: port-level properties of the next-PC unit, bound to its top.
// Assumes: default layout (branch and jump opcodes 5 and 2, ALIGN of 2).
module nextpc_unit_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned INSTR_W    = 32,
    parameter int unsigned OPC_W      = 6,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned TGT_W      = 26,
    parameter int unsigned ALIGN      = 2,
    parameter int unsigned OPC_BRANCH = 5,
    parameter int unsigned OPC_JUMP   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [INSTR_W-1:0] instr,
    input logic               cond_true,
    input logic [ADDR_W-1:0]  pc
);

    localparam int unsigned UP_W  = ADDR_W - TGT_W - ALIGN;
    localparam int unsigned EXT_W = ADDR_W - OFF_W - ALIGN;
    localparam logic [OPC_W-1:0] BR = OPC_W'(OPC_BRANCH);
    localparam logic [OPC_W-1:0] JP = OPC_W'(OPC_JUMP);

    logic [OPC_W-1:0] opc;
    logic             rst_seen_q;

    assign opc = instr[INSTR_W-1 -: OPC_W];

    // Remember that reset was sampled at the last edge
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: after a reset edge the counter reads zero
    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_zero_R1: assert (pc == '0);
        end
    end

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pc == $past(pc));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opc != JP && opc != BR) |=> pc == $past(pc) + ADDR_W'(4));

    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opc == BR && cond_true) |=>
        pc == $past(pc) + {{EXT_W{$past(instr[OFF_W-1])}}, $past(instr[OFF_W-1:0]), {ALIGN{1'b0}}});

    assert_branch_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opc == BR && !cond_true) |=> pc == $past(pc) + ADDR_W'(4));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opc == JP) |=>
        pc == {$past(pc[ADDR_W-1 -: UP_W]), $past(instr[TGT_W-1:0]), {ALIGN{1'b0}}});

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> pc[ALIGN-1:0] == '0);

endmodule

bind nextpc_unit nextpc_unit_chk #(
    .ADDR_W     (ADDR_W),
    .INSTR_W    (INSTR_W),
    .OPC_W      (OPC_W),
    .OFF_W      (OFF_W),
    .TGT_W      (TGT_W),
    .ALIGN      (ALIGN),
    .OPC_BRANCH (OPC_BRANCH),
    .OPC_JUMP   (OPC_JUMP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .instr     (instr),
    .cond_true (cond_true),
    .pc        (pc)
);

// File: tb/nextpc_unit_test.sv
// Module: nextpc_unit_test
// Purpose: directed bench for nextpc_unit; each task checks its own results.
module nextpc_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [31:0] instr;
    logic        cond_true;
    logic [31:0] pc;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    nextpc_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .instr     (instr),
        .cond_true (cond_true),
        .pc        (pc)
    );

    // Free-running clock
    always #(CLK_PERIOD/2) clk = ~clk;

    // I-format word: opcode, two register fields, 16-bit offset
    function automatic logic [31:0] mk_i(input logic [5:0] opc, input logic [15:0] off);
        return {opc, 5'd17, 5'd18, off};
    endfunction

    // J-format word: opcode and 26-bit word target
    function automatic logic [31:0] mk_j(input logic [5:0] opc, input logic [25:0] tgt);
        return {opc, tgt};
    endfunction

    // Compare pc against an expected value and count the result
    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (pc !== exp) begin
            failures++;
            $display("FAIL %s pc=%h expected=%h", req, pc, exp);
        end
    endtask

    // Drive one cycle of inputs away from the edge, then sample after it
    task automatic step(input logic r, input logic e, input logic [31:0] w, input logic c);
        @(negedge clk);
        rst_n     = r;
        en        = e;
        instr     = w;
        cond_true = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        step(1'b0, 1'b1, mk_i(6'd0, 16'd0), 1'b0);
        check("R1 reset", 32'h0000_0000);
    endtask

    task automatic t_sequential;
        step(1'b1, 1'b1, mk_i(6'd0, 16'h0020), 1'b0);
        check("R3 seq opc0", 32'h0000_0004);
        step(1'b1, 1'b1, mk_i(6'd3, 16'h1234), 1'b0);
        check("R3 seq opc3", 32'h0000_0008);
    endtask

    task automatic t_branch_taken;
        step(1'b1, 1'b1, mk_i(6'd5, 16'h0003), 1'b1);
        check("R4 branch +3", 32'h0000_0014);
    endtask

    task automatic t_branch_not_taken;
        step(1'b1, 1'b1, mk_i(6'd5, 16'h0100), 1'b0);
        check("R6 branch fall", 32'h0000_0018);
    endtask

    task automatic t_cond_ignored;
        step(1'b1, 1'b1, mk_i(6'd4, 16'h0100), 1'b1);
        check("R8 opc4 cond", 32'h0000_001C);
    endtask

    task automatic t_stall;
        step(1'b1, 1'b0, mk_j(6'd2, 26'h3FF_FFFF), 1'b1);
        check("R2 hold jump", 32'h0000_001C);
        step(1'b1, 1'b0, mk_i(6'd5, 16'h0040), 1'b1);
        check("R2 hold branch", 32'h0000_001C);
    endtask

    task automatic t_negative_and_wrap;
        step(1'b1, 1'b1, mk_i(6'd5, 16'hFFF7), 1'b1);
        check("R5 branch -9", 32'hFFFF_FFF8);
        step(1'b1, 1'b1, mk_i(6'd0, 16'h0000), 1'b0);
        check("R3 seq high", 32'hFFFF_FFFC);
        step(1'b1, 1'b1, mk_i(6'd0, 16'h0000), 1'b0);
        check("R3 wrap", 32'h0000_0000);
        step(1'b1, 1'b1, mk_i(6'd5, 16'hFFFF), 1'b1);
        check("R5 branch -1", 32'hFFFF_FFFC);
    endtask

    task automatic t_jump;
        step(1'b1, 1'b1, mk_j(6'd2, 26'h012_3456), 1'b0);
        check("R7 jump", 32'hF048_D158);
        step(1'b1, 1'b1, mk_j(6'd2, 26'h3FF_FFFF), 1'b1);
        check("R7 jump cond", 32'hFFFF_FFFC);
    endtask

    task automatic t_offset_extremes;
        step(1'b1, 1'b1, mk_i(6'd5, 16'h8000), 1'b1);
        check("R5 branch min", 32'hFFFD_FFFC);
        step(1'b1, 1'b1, mk_i(6'd5, 16'h7FFF), 1'b1);
        check("R4 branch max", 32'hFFFF_FFF8);
    endtask

    task automatic t_reset_while_stalled;
        step(1'b0, 1'b0, mk_j(6'd2, 26'h155_5555), 1'b1);
        check("R1 reset en low", 32'h0000_0000);
        step(1'b1, 1'b1, mk_j(6'd2, 26'h155_5555), 1'b0);
        check("R7 jump low nibble", 32'h0555_5554);
    endtask

    // Directed sequence
    initial begin
        rst_n     = 1'b0;
        en        = 1'b1;
        instr     = '0;
        cond_true = 1'b0;
        t_reset();
        t_sequential();
        t_branch_taken();
        t_branch_not_taken();
        t_cond_ignored();
        t_stall();
        t_negative_and_wrap();
        t_jump();
        t_offset_extremes();
        t_reset_while_stalled();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog pc=%h expected=finished", pc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule